// File: doc/BRIEF.md
# I2C Controller Interrupt Status Block

This block collects the event indications of an I2C controller into one interrupt line. Ten of its twelve sources are edge events: a one-cycle pulse sets a sticky bit that stays set until software clears it. The other two, receive-full and transmit-empty, are threshold levels from the FIFOs. They are shown live in the status and cannot be cleared. A mask register chooses which raw bits reach the masked status view and the interrupt output.

Software clears a sticky source by reading that source's own clear address. Clearing one source this way cannot drop an event on another source that arrives between the status read and the clear. There is also a single address that clears every sticky source at once. A separate register collects the reasons for a transmit abort. It is emptied only by reading the tx-abort clear address, so software must save it before that read.

Register reads return data one cycle after the request. A read of a clear address returns the state of the bit before the clear takes effect.

Top module: `irq_status_regs`

## Requirements
- R1: Status bits, from bit 0: rx underflow, rx overflow, rx full, tx overflow, tx empty, read request, tx abort, rx done, activity, stop detect, start detect, general call. A pulse on `evt_pulse[i]` sets sticky raw bit i (all bits except 2 and 4), and the bit stays set while no clear occurs. Raw status is read at 0x34.
- R2: Raw bit 2 follows `rx_full_lvl` and raw bit 4 follows `tx_empty_lvl` in the same cycle. Neither bit is sticky, and no clear read affects either one.
- R3: The masked status, read at 0x2C, equals raw status AND the mask register.
- R4: `irq` is high exactly when some masked status bit is set. It is low whenever the mask is zero.
- R5: Reading a source's clear address clears only that source's raw bit. The addresses, in bit order, are: 0x44 for bit 0, 0x48 for bit 1, 0x4C for bit 3, 0x50 for bit 5, 0x54 for bit 6, 0x58 for bit 7, 0x5C for bit 8, 0x60 for bit 9, 0x64 for bit 10 and 0x68 for bit 11.
- R6: Reading 0x40 clears all sticky raw bits at once. Reading it returns, in bit 0, whether any sticky bit was set.
- R7: When an event pulse arrives in the same cycle as a clear read of its bit, the event wins and the bit stays set.
- R8: Abort reasons on `abrt_why` are ORed into the abort-reason register at 0x80, which accumulates them. Bits 6 and 8 are reserved and always read 0.
- R9: The abort-reason register is cleared only by a read of 0x54. The combined clear at 0x40 leaves it unchanged. Reasons that arrive in the same cycle as the 0x54 read are kept.
- R10: `rd_data` is updated one cycle after `rd_en` and reflects state from before that cycle's clear. A per-source clear read returns the old bit in bit 0.
- R11: After reset, the sticky bits, the mask and the abort reasons are all zero, and `irq` is low.
- R12: A write with `wr_en` to 0x30 loads the mask from `wr_data`. The mask reads back at 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | One-cycle event pulses, one per status bit |
| rx_full_lvl | input | 1 | Receive FIFO threshold level |
| tx_empty_lvl | input | 1 | Transmit FIFO threshold level |
| abrt_why | input | 13 | Transmit abort reason pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 12 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |

## Verification
Each sticky source is set together with every other sticky source and then cleared through its own address. A clear that removed any other bit, or one aimed at the wrong address, shows up as a different raw value. A single stop-detect bit under a matching mask, and the same bit under an empty mask, show whether the mask gates both the masked status and the interrupt line. The combined clear is run with a FIFO level held high, which shows that level bits are not sticky. A clear read is issued in the same cycle as a new event, which exposes the wrong choice of winner. Abort reasons are fed in several pulses that include the reserved bits, then put through a combined clear and a tx-abort clear, which shows accumulation, reserved-bit masking and which clear empties the register.

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       evt_pulse,
  input  logic              rx_full_lvl,
  input  logic              tx_empty_lvl,
  input  logic [12:0]       abrt_why,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [11:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [11:0] STICKY = 12'hFEB;
  localparam logic [12:0] WHY_OK = 13'h1EBF;
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_CLALL = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_WHY   = ADDR_W'(8'h80);

  function automatic logic [ADDR_W-1:0] clr_addr(input int i);
    int s;
    s = i;
    if (i > 2) s = s - 1;
    if (i > 4) s = s - 1;
    return ADDR_W'(68 + 4 * s);
  endfunction

  logic [11:0] sticky_q, mask_q, raw, masked, clr_hit;
  logic [12:0] abort_q;
  logic [DATA_W-1:0] rd_next;
  logic why_clr;

  for (genvar gi = 0; gi < 12; gi++) begin : g_clr
    if (STICKY[gi]) begin : g_s
      assign clr_hit[gi] = rd_en && (rd_addr == clr_addr(gi) || rd_addr == A_CLALL);
    end else begin : g_l
      assign clr_hit[gi] = 1'b0;
    end
  end

  assign raw     = sticky_q | (12'(tx_empty_lvl) << 4) | (12'(rx_full_lvl) << 2);
  assign masked  = raw & mask_q;
  assign irq     = |masked;
  assign why_clr = rd_en && rd_addr == clr_addr(6);

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_MSTAT: rd_next = DATA_W'(masked);
      A_MASK:  rd_next = DATA_W'(mask_q);
      A_RAW:   rd_next = DATA_W'(raw);
      A_CLALL: rd_next = DATA_W'(|sticky_q);
      A_WHY:   rd_next = DATA_W'(abort_q);
      default:
        for (int i = 0; i < 12; i++)
          if (STICKY[i] && rd_addr == clr_addr(i)) rd_next = DATA_W'(sticky_q[i]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
      abort_q  <= '0;
      rd_data  <= '0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_hit) | evt_pulse) & STICKY;
      abort_q  <= (why_clr ? 13'd0 : abort_q) | (abrt_why & WHY_OK);
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

module irq_status_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [11:0]       evt_pulse,
  input logic [12:0]       abrt_why,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              irq,
  input logic [11:0]       sticky_q,
  input logic [11:0]       mask_q,
  input logic [12:0]       abort_q
);
  p_sticky_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[9] |=> sticky_q[9]);
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[0] && rd_en && rd_addr == ADDR_W'(8'h44)) |=> sticky_q[0]);
  p_own_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(8'h44) && !evt_pulse[0]) |=> !sticky_q[0]);
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(8'h40) && evt_pulse == 12'd0) |=> sticky_q == 12'd0);
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 12'd0) |-> !irq);
  p_why_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == ADDR_W'(8'h54)) |=> (abort_q & $past(abort_q)) == $past(abort_q));
  p_why_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(8'h54) && abrt_why == 13'd0) |=> abort_q == 13'd0);
  p_why_resv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_q[6] && !abort_q[8]);
endmodule

bind irq_status_regs irq_status_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .abrt_why(abrt_why),
  .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq), .sticky_q(sticky_q),
  .mask_q(mask_q), .abort_q(abort_q)
);

// File: tb/irq_status_regs_test.sv
module irq_status_regs_test;
  logic clk = 0, rst_n = 0;
  logic [11:0] evt_pulse = '0, wr_data = '0;
  logic rx_full_lvl = 0, tx_empty_lvl = 0, wr_en = 0, rd_en = 0;
  logic [12:0] abrt_why = '0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] rd_data;
  logic irq;

  irq_status_regs uut (.*);

  always #2 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit chk_next = 0;

  always @(negedge clk) begin
    if (chk_next && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
      end
    end
    chk_next = rd_en;
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                    input logic [11:0] ev = '0);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    rd_en = 1; rd_addr = a; evt_pulse = ev;
    @(posedge clk); #1;
    rd_en = 0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [12:0] why = '0);
    @(posedge clk); #1;
    evt_pulse = ev; abrt_why = why;
    @(posedge clk); #1;
    evt_pulse = '0; abrt_why = '0;
  endtask

  task automatic wmask(input logic [11:0] m);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 8'h30; wr_data = m;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic drain();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bit_tbl[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_irq(0, "R11 irq after reset");
    rd(8'h34, 32'h0, "R11 raw after reset");
    rd(8'h30, 32'h0, "R11 mask after reset");
    rd(8'h80, 32'h0, "R11 abort reasons after reset");

    pulse(12'h201);
    repeat (4) @(posedge clk);
    rd(8'h34, 32'h201, "R1 sticky bits held");
    chk_irq(0, "R4 irq low with zero mask");

    rx_full_lvl = 1;
    rd(8'h34, 32'h205, "R2 rx full level shown");
    rx_full_lvl = 0; tx_empty_lvl = 1;
    rd(8'h34, 32'h211, "R2 rx full gone, tx empty shown");
    tx_empty_lvl = 0;

    wmask(12'h200);
    rd(8'h30, 32'h200, "R12 mask readback");
    rd(8'h2C, 32'h200, "R3 masked status");
    chk_irq(1, "R4 irq on masked bit");

    rd(8'h60, 32'h1, "R10 stop clear returns old bit");
    rd(8'h34, 32'h001, "R5 stop clear leaves other bit");
    chk_irq(0, "R4 irq drops after clear");
    rd(8'h44, 32'h1, "R5 rx underflow clear returns set");
    rd(8'h44, 32'h0, "R5 second clear returns zero");
    rd(8'h34, 32'h0, "R5 raw empty");

    for (int k = 0; k < 10; k++) begin
      pulse(12'hFEB);
      rd(8'(68 + 4 * k), 32'h1, $sformatf("R5 clear slot %0d returns set", k));
      rd(8'h34, 32'hFEB & ~(32'h1 << bit_tbl[k]), $sformatf("R5 clear slot %0d only own bit", k));
      rd(8'h40, 32'h1, "R6 combined clear saw bits");
    end

    pulse(12'hFEB);
    rx_full_lvl = 1;
    rd(8'h40, 32'h1, "R6 combined clear returns any");
    rd(8'h34, 32'h004, "R6 only level bit remains");
    rd(8'h40, 32'h0, "R6 combined clear after empty");
    rx_full_lvl = 0;

    rd(8'h64, 32'h0, "R7 clear read returns old zero", 12'h400);
    rd(8'h34, 32'h400, "R7 event wins over clear");
    rd(8'h64, 32'h1, "R7 later clear returns set");
    rd(8'h34, 32'h0, "R7 later clear takes effect");

    pulse(12'h040, 13'h0001);
    pulse(12'h000, 13'h1000);
    pulse(12'h000, 13'h0140);
    rd(8'h80, 32'h1001, "R8 reasons accumulate, reserved dropped");
    rd(8'h40, 32'h1, "R9 combined clear");
    rd(8'h80, 32'h1001, "R9 combined clear keeps reasons");
    pulse(12'h040);
    rd(8'h54, 32'h1, "R9 abort clear returns set");
    rd(8'h80, 32'h0, "R9 reasons cleared by abort clear");
    rd(8'h34, 32'h0, "R9 abort bit cleared");

    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule